// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table out of memory. A requester presents the virtual address, the table base and a tiny-page enable on a valid/ready handshake. The walker then reads one or two 32-bit descriptors over a simple read port. The first descriptor resolves either to a 1 MB section or to a pointer at a coarse or fine second-level table. The second descriptor resolves to a large, small or tiny page.

When the walk ends, the walker pulses a done strobe for one cycle. With it come either the translated address, a page-type code, the domain, the cacheable/bufferable pair and the access-permission field, or a fault flag. One walk is in flight at a time. The read port may stall for any number of cycles.

Top module: `ptw_top`

## Requirements
- R1: The first read goes to address {ttb[31:14], va[31:20], 2'b00}. It is issued in the cycle after the request is accepted.
- R2: A first-level descriptor with bits [1:0] = 0 ends the walk with fault_o = 1 after a single read. So does bits [1:0] = 3 when tiny_en_i was low at acceptance. On any fault, pa_o, ptype_o, domain_o, cb_o and ap_o are all zero.
- R3: A first-level descriptor with bits [1:0] = 2 is a section and the walk ends after one read. The outputs are ptype_o = 0, pa_o = {desc[31:20], va[19:0]}, cb_o = desc[3:2] and ap_o = {6'b0, desc[11:10]}.
- R4: For first-level bits [1:0] = 1 (coarse), the second read address is {desc1[31:10], va[19:12], 2'b00}.
- R5: For first-level bits [1:0] = 3 (fine) with tiny_en_i high, the second read address is {desc1[31:12], va[19:10], 2'b00}.
- R6: A second-level descriptor with bits [1:0] = 0 ends the walk with fault_o = 1 after two reads.
- R7: Second-level bits [1:0] = 1 give a large page. The outputs are ptype_o = 1, pa_o = {desc2[31:16], va[15:0]} and ap_o = desc2[11:4].
- R8: Second-level bits [1:0] = 2 give a small page. The outputs are ptype_o = 2, pa_o = {desc2[31:12], va[11:0]} and ap_o = desc2[11:4].
- R9: Second-level bits [1:0] = 3 give a tiny page. The outputs are ptype_o = 3, pa_o = {desc2[31:10], va[9:0]} and ap_o = {6'b0, desc2[5:4]}.
- R10: For every successful walk, domain_o equals first-level bits [8:5]. For two-level walks, cb_o equals second-level bits [3:2].
- R11: req_ready_o is high only while idle. A request is taken when req_valid_i and req_ready_o are both high. Requests presented while busy are ignored. done_o is a single-cycle pulse, and ready returns in the cycle after it.
- R12: mem_req_o and mem_addr_o stay constant from the start of a read until mem_rvalid_i is seen. Any number of wait cycles is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_va_i | input | 32 | Virtual address to translate |
| req_ttb_i | input | 32 | Translation table base (bits [13:0] unused) |
| tiny_en_i | input | 1 | Allows fine second-level tables, sampled at acceptance |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid, ends the current read |
| mem_rdata_i | input | 32 | Read descriptor word |
| done_o | output | 1 | One-cycle walk completion strobe |
| fault_o | output | 1 | Translation fault, qualified by done_o |
| pa_o | output | 32 | Physical address |
| ptype_o | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| domain_o | output | 4 | Domain field |
| cb_o | output | 2 | Cacheable/bufferable bits |
| ap_o | output | 8 | Access-permission field, zero-extended when 2 bits |

## Verification
Some properties are checked on every cycle. These are the handshake invariants: ready only while idle, a single-cycle done, and no read issued while idle. They also cover stability of the read request and address through wait states, address alignment, the first-level address formed from the accepted request, zeroed outputs on fault, and the upper permission bits being clear for sections and tiny pages. Only the bench scenarios can show whether each descriptor encoding produces the right address splice, page type, domain, permission and read count, against a memory model with varied latency. The same holds for the tiny-enable switch turning fine tables into faults, and for requests presented mid-walk leaving the result untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned DOM_W = 4;
  localparam int unsigned CB_W  = 2;
  localparam int unsigned AP_W  = 8;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } page_e;

  // first-level descriptor type field, bits [1:0]
  typedef enum logic [1:0] {
    L1_FAULT   = 2'd0,
    L1_COARSE  = 2'd1,
    L1_SECTION = 2'd2,
    L1_FINE    = 2'd3
  } l1_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic [XLEN-1:0]  pa;
    page_e            ptype;
    logic [DOM_W-1:0] dom;
    logic [CB_W-1:0]  cb;
    logic [AP_W-1:0]  ap;
  } xlat_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned AW         = XLEN,
  parameter int unsigned SEC_BITS   = 20,
  parameter int unsigned COARSE_LSB = 12,
  parameter int unsigned FINE_LSB   = 10,
  localparam int unsigned TTB_LSB   = (AW - SEC_BITS) + 2,
  localparam int unsigned CT_LSB    = (SEC_BITS - COARSE_LSB) + 2,
  localparam int unsigned FT_LSB    = (SEC_BITS - FINE_LSB) + 2
) (
  input  logic [AW-1:0]      va_i,
  input  logic [AW-1:TTB_LSB] tbase_i,
  input  logic [AW-1:CT_LSB] l2base_i,
  input  logic               fine_i,
  output logic [AW-1:0]      l1_addr_o,
  output logic [AW-1:0]      l2_addr_o
);
  logic [AW-1:0] coarse_addr;
  logic [AW-1:0] fine_addr;

  assign l1_addr_o   = {tbase_i, va_i[AW-1:SEC_BITS], 2'b00};
  assign coarse_addr = {l2base_i, va_i[SEC_BITS-1:COARSE_LSB], 2'b00};
  assign fine_addr   = {l2base_i[AW-1:FT_LSB], va_i[SEC_BITS-1:FINE_LSB], 2'b00};
  assign l2_addr_o   = fine_i ? fine_addr : coarse_addr;
endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
#(
  parameter int unsigned AW       = XLEN,
  parameter int unsigned SEC_BITS = 20
) (
  input  logic [AW-1:0]       desc_i,
  input  logic [SEC_BITS-1:0] va_lo_i,
  input  logic                tiny_en_i,
  output l1_kind_e            kind_o,
  output xlat_t               sec_o
);
  logic unused_desc;
  assign unused_desc = ^{desc_i[SEC_BITS-1:12], desc_i[9], desc_i[4]};

  always_comb begin
    kind_o = l1_kind_e'(desc_i[1:0]);
    if (kind_o == L1_FINE && !tiny_en_i) kind_o = L1_FAULT;
  end

  always_comb begin
    sec_o       = '0;
    sec_o.pa    = {desc_i[AW-1:SEC_BITS], va_lo_i};
    sec_o.ptype = PG_SECTION;
    sec_o.dom   = desc_i[8:5];
    sec_o.cb    = desc_i[3:2];
    sec_o.ap    = {{(AP_W-2){1'b0}}, desc_i[11:10]};
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
#(
  parameter int unsigned AW      = XLEN,
  parameter int unsigned LG_BITS = 16,
  parameter int unsigned SM_BITS = 12,
  parameter int unsigned TN_BITS = 10
) (
  input  logic [AW-1:0]      desc_i,
  input  logic [LG_BITS-1:0] va_lo_i,
  input  logic [DOM_W-1:0]   dom_i,
  output logic               fault_o,
  output xlat_t              pg_o
);
  always_comb begin
    fault_o  = 1'b0;
    pg_o     = '0;
    pg_o.dom = dom_i;
    pg_o.cb  = desc_i[3:2];
    unique case (desc_i[1:0])
      2'd1: begin
        pg_o.ptype = PG_LARGE;
        pg_o.pa    = {desc_i[AW-1:LG_BITS], va_lo_i};
        pg_o.ap    = desc_i[11:4];
      end
      2'd2: begin
        pg_o.ptype = PG_SMALL;
        pg_o.pa    = {desc_i[AW-1:SM_BITS], va_lo_i[SM_BITS-1:0]};
        pg_o.ap    = desc_i[11:4];
      end
      2'd3: begin
        pg_o.ptype = PG_TINY;
        pg_o.pa    = {desc_i[AW-1:TN_BITS], va_lo_i[TN_BITS-1:0]};
        pg_o.ap    = {{(AP_W-2){1'b0}}, desc_i[5:4]};
      end
      default: begin
        fault_o = 1'b1;
        pg_o    = '0;
      end
    endcase
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned AW         = XLEN,
  parameter int unsigned SEC_BITS   = 20,
  parameter int unsigned COARSE_LSB = 12,
  parameter int unsigned FINE_LSB   = 10,
  parameter int unsigned LG_BITS    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_va_i,
  input  logic [AW-1:0]    req_ttb_i,
  input  logic             tiny_en_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [AW-1:0]    pa_o,
  output logic [1:0]       ptype_o,
  output logic [DOM_W-1:0] domain_o,
  output logic [CB_W-1:0]  cb_o,
  output logic [AP_W-1:0]  ap_o
);
  localparam int unsigned TTB_LSB = (AW - SEC_BITS) + 2;
  localparam int unsigned CT_LSB  = (SEC_BITS - COARSE_LSB) + 2;

  state_e                 state_q;
  logic [AW-1:0]          va_q;
  logic [AW-1:TTB_LSB]    tbase_q;
  logic                   tiny_q;
  logic [AW-1:CT_LSB]     l2base_q;
  logic                   fine_q;
  logic [DOM_W-1:0]       dom_q;
  xlat_t                  res_q;
  logic                   fault_q;

  logic [AW-1:0] l1_addr, l2_addr;
  l1_kind_e      l1_kind;
  xlat_t         sec_res, pg_res;
  logic          l2_fault;

  logic unused_ttb;
  assign unused_ttb = ^req_ttb_i[TTB_LSB-1:0];

  ptw_addr_gen #(
    .AW(AW), .SEC_BITS(SEC_BITS), .COARSE_LSB(COARSE_LSB), .FINE_LSB(FINE_LSB)
  ) u_addr (
    .va_i     (va_q),
    .tbase_i  (tbase_q),
    .l2base_i (l2base_q),
    .fine_i   (fine_q),
    .l1_addr_o(l1_addr),
    .l2_addr_o(l2_addr)
  );

  ptw_l1_decode #(.AW(AW), .SEC_BITS(SEC_BITS)) u_l1 (
    .desc_i   (mem_rdata_i),
    .va_lo_i  (va_q[SEC_BITS-1:0]),
    .tiny_en_i(tiny_q),
    .kind_o   (l1_kind),
    .sec_o    (sec_res)
  );

  ptw_l2_decode #(.AW(AW), .LG_BITS(LG_BITS), .SM_BITS(COARSE_LSB), .TN_BITS(FINE_LSB)) u_l2 (
    .desc_i (mem_rdata_i),
    .va_lo_i(va_q[LG_BITS-1:0]),
    .dom_i  (dom_q),
    .fault_o(l2_fault),
    .pg_o   (pg_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      tbase_q  <= '0;
      tiny_q   <= 1'b0;
      l2base_q <= '0;
      fine_q   <= 1'b0;
      dom_q    <= '0;
      res_q    <= '0;
      fault_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          tbase_q <= req_ttb_i[AW-1:TTB_LSB];
          tiny_q  <= tiny_en_i;
          state_q <= ST_RD1;
        end
        ST_RD1: if (mem_rvalid_i) begin
          l2base_q <= mem_rdata_i[AW-1:CT_LSB];
          fine_q   <= (l1_kind == L1_FINE);
          dom_q    <= mem_rdata_i[8:5];
          unique case (l1_kind)
            L1_FAULT: begin
              res_q   <= '0;
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end
            L1_SECTION: begin
              res_q   <= sec_res;
              fault_q <= 1'b0;
              state_q <= ST_DONE;
            end
            default: state_q <= ST_RD2;
          endcase
        end
        ST_RD2: if (mem_rvalid_i) begin
          res_q   <= l2_fault ? '0 : pg_res;
          fault_q <= l2_fault;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_addr_o  = (state_q == ST_RD2) ? l2_addr : l1_addr;
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = fault_q;
  assign pa_o        = res_q.pa;
  assign ptype_o     = res_q.ptype;
  assign domain_o    = res_q.dom;
  assign cb_o        = res_q.cb;
  assign ap_o        = res_q.ap;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [11:0] va_hi_i,
  input logic [17:0] tbase_i,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        done_o,
  input logic        fault_o,
  input logic [31:0] pa_o,
  input logic [1:0]  ptype_o,
  input logic [3:0]  domain_o,
  input logic [1:0]  cb_o,
  input logic [7:0]  ap_o
);
  a_r1_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o &&
      mem_addr_o == {$past(tbase_i), $past(va_hi_i), 2'b00});

  a_r1_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r2_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> pa_o == '0 && ptype_o == '0 && domain_o == '0 &&
      cb_o == '0 && ap_o == '0);

  a_r3_section_ap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && ptype_o == 2'd0 |-> ap_o[7:2] == '0);

  a_r9_tiny_ap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && ptype_o == 2'd3 |-> ap_o[7:2] == '0);

  a_r11_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o);

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
endmodule

bind ptw_top ptw_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .va_hi_i     (req_va_i[31:20]),
  .tbase_i     (req_ttb_i[31:14]),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .pa_o        (pa_o),
  .ptype_o     (ptype_o),
  .domain_o    (domain_o),
  .cb_o        (cb_o),
  .ap_o        (ap_o)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0, req_ttb = '0;
  logic        tiny_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done, fault;
  logic [31:0] pa;
  logic [1:0]  ptype, cb;
  logic [3:0]  dom;
  logic [7:0]  ap;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ptw_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_ttb_i(req_ttb), .tiny_en_i(tiny_en),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault), .pa_o(pa),
    .ptype_o(ptype), .domain_o(dom), .cb_o(cb), .ap_o(ap)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] ttb;
    logic [31:0] d1;
    logic [31:0] d2;
    logic        tiny;
    logic [3:0]  lat;
    logic        efault;
    logic [1:0]  etype;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'h0000_4000, 32'hABC0_0DEE, 32'h0000_0000, 1'b1, 4'd0, 1'b0, 2'd0},
    '{32'h00AB_C123, 32'h8000_7FFF, 32'h0012_3421, 32'h8765_4FFA, 1'b1, 4'd2, 1'b0, 2'd2},
    '{32'hFFFF_FFFF, 32'hFFFF_C000, 32'h0000_0C01, 32'h1234_00F5, 1'b0, 4'd1, 1'b0, 2'd1},
    '{32'h7654_3210, 32'h0010_0000, 32'h4567_81E3, 32'hCAFE_BABF, 1'b1, 4'd3, 1'b0, 2'd3},
    '{32'h7654_3210, 32'h0010_0000, 32'h4567_81E3, 32'hCAFE_BABF, 1'b0, 4'd3, 1'b1, 2'd0},
    '{32'h0F00_0ABC, 32'h0002_0000, 32'h1111_1110, 32'h0000_0000, 1'b1, 4'd4, 1'b1, 2'd0},
    '{32'h3000_5000, 32'h0004_0000, 32'h2222_2201, 32'h3333_3330, 1'b1, 4'd0, 1'b1, 2'd0},
    '{32'hA5A5_A5A5, 32'h0000_8000, 32'h5555_5163, 32'h9999_9A06, 1'b1, 4'd7, 1'b0, 2'd2},
    '{32'h0123_4567, 32'hC000_0000, 32'h0F0F_0F01, 32'h1357_9BDF, 1'b1, 4'd2, 1'b0, 2'd3},
    '{32'hDEAD_BEEF, 32'h0008_C000, 32'h6000_0003, 32'hFEDC_BA99, 1'b1, 4'd0, 1'b0, 2'd1}
  };

  // memory model state
  logic [31:0] m_d1, m_d2, seen1, seen2;
  int          m_lat = 0;
  int          n_reads = 0;
  bit          stab_err = 1'b0;

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst_ni && mem_req) begin
        logic [31:0] a0;
        a0 = mem_addr;
        for (int k = 0; k < m_lat; k++) begin
          @(negedge clk);
          if (!mem_req || mem_addr != a0) stab_err = 1'b1;
        end
        if (n_reads == 0) begin
          seen1 = a0; mem_rdata = m_d1;
        end else begin
          seen2 = a0; mem_rdata = m_d2;
        end
        n_reads++;
        mem_rvalid = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] t);
    case (t)
      2'd0: return "R3";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  // reference model built from the requirements
  task automatic ref_walk(input vec_t v, output bit f, output logic [31:0] epa,
                          output logic [1:0] et, output logic [3:0] ed,
                          output logic [1:0] ec, output logic [7:0] ea,
                          output int nrd, output logic [31:0] l2a);
    f = 1'b0; epa = '0; et = '0; ed = '0; ec = '0; ea = '0; nrd = 1;
    l2a = (v.d1[1:0] == 2'd1) ? {v.d1[31:10], v.va[19:12], 2'b00}
                               : {v.d1[31:12], v.va[19:10], 2'b00};
    if (v.d1[1:0] == 2'd0 || (v.d1[1:0] == 2'd3 && !v.tiny)) begin
      f = 1'b1;
    end else if (v.d1[1:0] == 2'd2) begin
      epa = {v.d1[31:20], v.va[19:0]}; et = 2'd0; ed = v.d1[8:5];
      ec = v.d1[3:2]; ea = {6'b0, v.d1[11:10]};
    end else begin
      nrd = 2;
      ed = v.d1[8:5]; ec = v.d2[3:2];
      case (v.d2[1:0])
        2'd0: begin f = 1'b1; ed = '0; ec = '0; end
        2'd1: begin epa = {v.d2[31:16], v.va[15:0]}; et = 2'd1; ea = v.d2[11:4]; end
        2'd2: begin epa = {v.d2[31:12], v.va[11:0]}; et = 2'd2; ea = v.d2[11:4]; end
        default: begin epa = {v.d2[31:10], v.va[9:0]}; et = 2'd3; ea = {6'b0, v.d2[5:4]}; end
      endcase
    end
  endtask

  task automatic run_walk(input vec_t v, input bit busy_noise, input int idx);
    bit f; logic [31:0] epa, l2a; logic [1:0] et, ec; logic [3:0] ed; logic [7:0] ea;
    int nrd, cnt;
    ref_walk(v, f, epa, et, ed, ec, ea, nrd, l2a);
    chk(f == v.efault && (f || et == v.etype), "R2", $sformatf("table[%0d] model", idx),
        {30'b0, et}, {30'b0, v.etype});
    @(negedge clk);
    cnt = 0;
    while (!req_ready && cnt < 100) begin @(negedge clk); cnt++; end
    m_d1 = v.d1; m_d2 = v.d2; m_lat = int'(v.lat);
    n_reads = 0; stab_err = 1'b0; seen1 = 'x; seen2 = 'x;
    req_valid = 1'b1; req_va = v.va; req_ttb = v.ttb; tiny_en = v.tiny;
    @(negedge clk);
    if (busy_noise) begin
      chk(!req_ready, "R11", "ready low while busy", {31'b0, req_ready}, 32'd0);
      req_va = ~v.va; req_ttb = ~v.ttb; tiny_en = ~v.tiny;
    end else begin
      req_valid = 1'b0;
    end
    cnt = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    req_valid = 1'b0;
    chk(done, "R11", "done seen", {31'b0, done}, 32'd1);
    chk(fault == f, f ? ((nrd == 2) ? "R6" : "R2") : tag_of(et), "fault",
        {31'b0, fault}, {31'b0, f});
    chk(seen1 == {v.ttb[31:14], v.va[31:20], 2'b00}, "R1", "first read address",
        seen1, {v.ttb[31:14], v.va[31:20], 2'b00});
    chk(n_reads == nrd, (nrd == 1) ? "R3" : "R4", "read count", n_reads, nrd);
    if (nrd == 2)
      chk(seen2 == l2a, (v.d1[1:0] == 2'd3) ? "R5" : "R4", "second read address", seen2, l2a);
    chk(!stab_err, "R12", "request held through wait", {31'b0, stab_err}, 32'd0);
    if (f) begin
      chk(pa == '0 && ap == '0 && cb == '0 && dom == '0 && ptype == '0, "R2",
          "fault outputs zero", pa, 32'd0);
    end else begin
      chk(ptype == et, tag_of(et), "page type", {30'b0, ptype}, {30'b0, et});
      chk(pa == epa, tag_of(et), "physical address", pa, epa);
      chk(ap == ea, tag_of(et), "access permission", {24'b0, ap}, {24'b0, ea});
      chk(dom == ed, "R10", "domain", {28'b0, dom}, {28'b0, ed});
      chk(cb == ec, "R10", "cacheable/bufferable", {30'b0, cb}, {30'b0, ec});
    end
    @(negedge clk);
    chk(!done && req_ready, "R11", "done single cycle, ready back",
        {30'b0, done, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready, "R11", "ready in reset", {31'b0, req_ready}, 32'd1);
    chk(!done && !mem_req, "R11", "no done or read in reset", {30'b0, done, mem_req}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req, "R11", "idle after reset", {30'b0, req_ready, mem_req}, 32'd2);

    for (int i = 0; i < NV; i++) run_walk(VECS[i], 1'b0, i);

    // R11: requests held during a walk are ignored
    run_walk(VECS[7], 1'b1, 7);
    run_walk(VECS[0], 1'b1, 0);
    // R12: longest wait on both reads
    begin
      vec_t v;
      v = VECS[1];
      v.lat = 4'd15;
      run_walk(v, 1'b0, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule